// File: doc/BRIEF.md
# CAN Transmit Bit Stuffer with Arbitration Monitor

This block is the bit-level transmit path of a CAN node. An upstream frame builder hands it one frame bit at a time over a valid/ready stream. Each bit carries a field code that says whether it belongs to the arbitration field, to a stuffed non-arbitration field (control, data, CRC) or to a fixed-form field (delimiters, acknowledge slot, end of frame). The block drives the bits onto the transmit pin at one bit per clock. In this block one clock cycle is one bit time; bit timing lives elsewhere. In stuffed fields it inserts a complementary stuff bit after five equal bits, so a run of six can never look like an error flag.

The bus is a wired-AND: logic 0 is dominant, and the bus reads 0 whenever any node drives 0. The block samples the receive pin in every bit time and compares it with what it sent. If it sends recessive in the arbitration field and reads dominant, it has lost arbitration. It then raises a flag and forces the pin recessive for the rest of the frame. It keeps draining the stream at the normal bit rate, so the frame timing seen by the builder does not change. Outside arbitration, any difference between the sent and sampled bit raises a one-cycle bit-error pulse.

The controller has three states. ST_IDLE drives recessive and waits for the first bit of a frame. ST_SEND drives a stream bit. ST_STUFF drives an inserted stuff bit. The transitions are:
- ST_IDLE to ST_SEND on a valid bit.
- ST_SEND to ST_STUFF when the bit on the pin completes a run of five in a stuffed field.
- ST_SEND to ST_IDLE after the last bit of the frame.
- ST_SEND to ST_SEND on the next valid bit, or to hold the bit when the stream stalls.
- ST_STUFF to ST_SEND on the next valid bit.
- ST_STUFF to ST_IDLE when the stuffed bit was the frame's last.

Top module: `can_bit_tx`

## Requirements
- R1: After reset the block is in ST_IDLE with tx_o = 1, in_ready = 1, arb_lost = 0 and bit_err = 0.
- R2: A bit accepted on a clock edge (in_valid and in_ready both high) is driven on tx_o for exactly the following cycle. Frame bits appear in acceptance order, one per cycle, while the stream keeps in_valid high.
- R3: Field codes on in_field are 2'b00 for arbitration, 2'b01 for stuffed non-arbitration and 2'b10 or 2'b11 for fixed form. In fields 2'b00 and 2'b01, after five consecutive equal bits on tx_o the next cycle carries one bit of the opposite value, and in_ready is low during the fifth bit. The stuff bit counts as the first bit of the next run.
- R4: A run of five that ends on the last stuffed bit before a fixed-form field still gets its stuff bit. Fixed-form bits are never stuffed and restart the run count. The run count also restarts at each frame start.
- R5: In the arbitration field, a cycle with tx_o = 1 and rx_i = 0 sets arb_lost from the next cycle. arb_lost stays high through the frame's last bit time, and tx_o stays 1 for that whole span.
- R6: A node that never reads 0 while sending 1 in the arbitration field keeps arb_lost low, and its frame continues with no added or repeated bit times.
- R7: In fields 2'b01 and 2'b10/2'b11, while arb_lost is low, a cycle with tx_o different from rx_i gives a one-cycle bit_err pulse in the next cycle.
- R8: bit_err never rises for a bit sent in the arbitration field, nor for any bit time while arb_lost is high.
- R9: In the cycle after the bit time of the frame's last bit (marked by in_last, plus any stuff bit it triggers), the block is back in ST_IDLE: tx_o = 1, in_ready = 1 and arb_lost = 0.
- R10: After losing arbitration the block keeps accepting the rest of the frame at the same rate and with the same stuffing schedule, so the frame occupies the same number of bit times as a won frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one bit time |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Frame bit offered |
| in_ready | output | 1 | Block takes the offered bit at this edge |
| in_bit | input | 1 | Frame bit value |
| in_field | input | 2 | Field code of the bit (see R3) |
| in_last | input | 1 | Marks the final bit of the frame |
| tx_o | output | 1 | Transmit pin, 1 = recessive |
| rx_i | input | 1 | Sampled bus level |
| arb_lost | output | 1 | Arbitration lost, held to end of frame |
| bit_err | output | 1 | One-cycle pulse on a bit mismatch outside arbitration |

## Verification
A bit accepted at an edge is on tx_o one cycle later. arb_lost and bit_err both follow the offending bit time by exactly one cycle. The return to idle comes one cycle after the last bit time. The bench drives inputs on the falling edge and samples 1 ns later, and it numbers the cycles of a frame from the first offered bit. It builds the expected stuffed bit list from the frame and computes the expected tx_o, arb_lost and bit_err for each cycle index from that list, applying these one-cycle offsets. The other node is modelled as a per-bit-time level ANDed into rx_i, so the loss and error points are known in advance.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;

    typedef enum logic [1:0] {
        FLD_ARB     = 2'b00,
        FLD_CTRL    = 2'b01,
        FLD_FIXED   = 2'b10,
        FLD_FIXED_X = 2'b11
    } field_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_STUFF
    } state_e;

    // stuffed fields are the arbitration and the stuffed control/data/CRC fields
    function automatic logic fld_is_stuffed(input logic [1:0] fld);
        return !fld[1];
    endfunction

endpackage

// File: rtl/can_run_tracker.sv
module can_run_tracker #(
    parameter int RUN_LIMIT = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic cur_bit,
    input  logic cur_stuffed,
    input  logic adv_data,
    input  logic adv_stuff,
    output logic stuff_due,
    output logic stuff_val
);
    localparam int CNT_W = $clog2(RUN_LIMIT + 1) + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             val_q;

    always_comb begin
        if (cnt_q != '0 && cur_bit == val_q) begin
            cnt_nxt = cnt_q + 1'b1;
        end else begin
            cnt_nxt = CNT_W'(1);
        end
        stuff_due = cur_stuffed && (cnt_nxt == CNT_W'(RUN_LIMIT));
        stuff_val = ~val_q;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
            val_q <= 1'b1;
        end else if (adv_stuff) begin
            cnt_q <= CNT_W'(1);
            val_q <= ~val_q;
        end else if (adv_data) begin
            if (cur_stuffed) begin
                cnt_q <= cnt_nxt;
                val_q <= cur_bit;
            end else begin
                cnt_q <= '0;
            end
        end
    end

endmodule

// File: rtl/can_bit_judge.sv
module can_bit_judge
    import can_tx_pkg::*;
(
    input  logic       active,
    input  logic       lost,
    input  logic [1:0] field,
    input  logic       tx_bit,
    input  logic       rx_bit,
    output logic       lose_now,
    output logic       err_now
);
    logic in_arb;

    always_comb begin
        in_arb   = (field == FLD_ARB);
        lose_now = active && !lost && in_arb && tx_bit && !rx_bit;
        err_now  = active && !lost && !in_arb && (tx_bit != rx_bit);
    end

endmodule

// File: rtl/can_bit_tx.sv
module can_bit_tx
    import can_tx_pkg::*;
#(
    parameter int RUN_LIMIT = 5,
    parameter int FIELD_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               in_bit,
    input  logic [FIELD_W-1:0] in_field,
    input  logic               in_last,
    output logic               tx_o,
    input  logic               rx_i,
    output logic               arb_lost,
    output logic               bit_err
);
    state_e             state_q, state_d;
    logic               cur_bit_q;
    logic [FIELD_W-1:0] cur_field_q;
    logic               cur_last_q;
    logic               lost_q;
    logic               err_q;

    logic stuff_due, stuff_val;
    logic adv_data, adv_stuff;
    logic take;
    logic lose_now, err_now;
    logic active;

    can_run_tracker #(
        .RUN_LIMIT(RUN_LIMIT)
    ) u_run (
        .clk        (clk),
        .rst        (rst),
        .clear      (state_q == ST_IDLE),
        .cur_bit    (cur_bit_q),
        .cur_stuffed(fld_is_stuffed(cur_field_q[1:0])),
        .adv_data   (adv_data),
        .adv_stuff  (adv_stuff),
        .stuff_due  (stuff_due),
        .stuff_val  (stuff_val)
    );

    can_bit_judge u_judge (
        .active  (active),
        .lost    (lost_q),
        .field   (cur_field_q[1:0]),
        .tx_bit  (tx_o),
        .rx_bit  (rx_i),
        .lose_now(lose_now),
        .err_now (err_now)
    );

    // next-state logic
    always_comb begin
        state_d   = state_q;
        adv_data  = 1'b0;
        adv_stuff = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) state_d = ST_SEND;
            end
            ST_SEND: begin
                if (stuff_due) begin
                    state_d  = ST_STUFF;
                    adv_data = 1'b1;
                end else if (cur_last_q) begin
                    state_d  = ST_IDLE;
                    adv_data = 1'b1;
                end else if (in_valid) begin
                    state_d  = ST_SEND;
                    adv_data = 1'b1;
                end
            end
            ST_STUFF: begin
                if (cur_last_q) begin
                    state_d   = ST_IDLE;
                    adv_stuff = 1'b1;
                end else if (in_valid) begin
                    state_d   = ST_SEND;
                    adv_stuff = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        active   = (state_q != ST_IDLE);
        in_ready = 1'b0;
        tx_o     = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                tx_o     = 1'b1;
            end
            ST_SEND: begin
                in_ready = !stuff_due && !cur_last_q;
                tx_o     = lost_q ? 1'b1 : cur_bit_q;
            end
            ST_STUFF: begin
                in_ready = !cur_last_q;
                tx_o     = lost_q ? 1'b1 : stuff_val;
            end
            default: begin
                in_ready = 1'b0;
                tx_o     = 1'b1;
            end
        endcase
        take     = in_valid && in_ready;
        arb_lost = lost_q;
        bit_err  = err_q;
    end

    // state register and frame datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            cur_bit_q   <= 1'b1;
            cur_field_q <= '0;
            cur_last_q  <= 1'b0;
            lost_q      <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_now;
            if (take) begin
                cur_bit_q   <= in_bit;
                cur_field_q <= in_field;
                cur_last_q  <= in_last;
            end
            if (state_d == ST_IDLE) begin
                lost_q <= 1'b0;
            end else if (lose_now) begin
                lost_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/can_bit_tx_chk.sv
module can_bit_tx_chk (
    input logic clk,
    input logic rst,
    input logic tx_o,
    input logic rx_i,
    input logic in_ready,
    input logic arb_lost,
    input logic bit_err
);
    // R5
    lost_forces_recessive_chk: assert property (@(posedge clk) disable iff (rst)
        arb_lost |-> tx_o);

    // R5
    lost_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(arb_lost) |-> ($past(tx_o) && !$past(rx_i)));

    // R7
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        bit_err |-> ($past(tx_o) != $past(rx_i)));

    // R8
    err_not_lost_chk: assert property (@(posedge clk) disable iff (rst)
        bit_err |-> !arb_lost);

    // R9
    end_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(arb_lost) |-> (in_ready && tx_o));

endmodule

bind can_bit_tx can_bit_tx_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .tx_o    (tx_o),
    .rx_i    (rx_i),
    .in_ready(in_ready),
    .arb_lost(arb_lost),
    .bit_err (bit_err)
);

// File: tb/can_bit_tx_tb.sv
`timescale 1ns/1ps
module can_bit_tx_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid, in_ready, in_bit, in_last;
    logic [1:0] in_field;
    logic       tx_o, rx_i, arb_lost, bit_err;
    logic       drv;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    assign rx_i = tx_o & drv;

    can_bit_tx u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_bit(in_bit), .in_field(in_field), .in_last(in_last),
        .tx_o(tx_o), .rx_i(rx_i), .arb_lost(arb_lost), .bit_err(bit_err)
    );

    localparam logic [1:0] F_ARB = 2'b00, F_CTRL = 2'b01, F_FIX = 2'b10;

    logic       fb [0:159];
    logic [1:0] ff [0:159];
    int         fn;
    logic       xb [0:255];
    logic [1:0] xf [0:255];
    int         xn;
    logic       ob [0:255];

    task automatic push(input logic [31:0] v, input int w, input logic [1:0] f);
        for (int k = w - 1; k >= 0; k--) begin
            fb[fn] = v[k]; ff[fn] = f; fn++;
        end
    endtask

    // expected stuffed bit list, from R3/R4
    task automatic expand();
        int   cnt;
        logic val;
        cnt = 0; val = 1'b1; xn = 0;
        for (int i = 0; i < fn; i++) begin
            xb[xn] = fb[i]; xf[xn] = ff[i]; xn++;
            if (!ff[i][1]) begin
                if (cnt > 0 && fb[i] == val) cnt++;
                else begin cnt = 1; val = fb[i]; end
                if (cnt == 5) begin
                    xb[xn] = ~val; xf[xn] = ff[i]; xn++;
                    val = ~val; cnt = 1;
                end
            end else begin
                cnt = 0;
            end
        end
    endtask

    task automatic build(input logic [10:0] id, input logic [3:0] dlc,
                         input logic [14:0] crc, input bit zero_data);
        int nb;
        fn = 0;
        push(0, 1, F_ARB);
        push({21'd0, id}, 11, F_ARB);
        push(0, 1, F_ARB);
        push(0, 2, F_CTRL);
        push({28'd0, dlc}, 4, F_CTRL);
        nb = (dlc > 8) ? 8 : int'(dlc);
        for (int b = 0; b < nb; b++)
            push(zero_data ? 32'd0 : ($urandom & 32'hFF), 8, F_CTRL);
        push({17'd0, crc}, 15, F_CTRL);
        push(1, 3, F_FIX);
        push(32'h7F, 7, F_FIX);
        for (int j = 0; j < 256; j++) ob[j] = 1'b1;
        expand();
    endtask

    task automatic report(input string tag, input string what, input int bad,
                          input int t, input logic a, input logic e);
        tests++;
        if (bad > 0) begin
            fails++;
            $display("FAIL %s %s at cycle %0d: actual %0b expected %0b (%0d mismatches)",
                     tag, what, t, a, e, bad);
        end
    endtask

    task automatic run_frame(input string tag);
        int   lost_at, idx;
        int   btx, blost, berr, tb_tx, tb_l, tb_e;
        logic ab_tx, eb_tx, ab_l, eb_l, ab_e, eb_e;
        logic e_tx, e_l, e_e, lv;
        int   j;
        bit   idle_ok;
        lost_at = -1;
        for (int k = 0; k < xn; k++)
            if (lost_at < 0 && xf[k] == F_ARB && xb[k] && !ob[k]) lost_at = k;
        idx = 0; btx = 0; blost = 0; berr = 0; idle_ok = 0;
        tb_tx = 0; tb_l = 0; tb_e = 0;
        ab_tx = 0; eb_tx = 0; ab_l = 0; eb_l = 0; ab_e = 0; eb_e = 0;
        for (int t = 0; t <= xn + 2; t++) begin
            @(negedge clk);
            in_valid = (idx < fn);
            if (idx < fn) begin
                in_bit = fb[idx]; in_field = ff[idx]; in_last = (idx == fn - 1);
            end else begin
                in_last = 1'b0;
            end
            drv = (t >= 1 && t <= xn) ? ob[t-1] : 1'b1;
            #1;
            lv   = (lost_at >= 0 && t >= lost_at + 2 && t <= xn);
            e_tx = (t >= 1 && t <= xn) ? (lv ? 1'b1 : xb[t-1]) : 1'b1;
            e_l  = lv;
            j    = t - 2;
            e_e  = (j >= 0 && j < xn && xf[j] != F_ARB && (lost_at < 0 || j < lost_at)
                    && xb[j] && !ob[j]);
            if (tx_o !== e_tx) begin
                if (btx == 0) begin tb_tx = t; ab_tx = tx_o; eb_tx = e_tx; end
                btx++;
            end
            if (arb_lost !== e_l) begin
                if (blost == 0) begin tb_l = t; ab_l = arb_lost; eb_l = e_l; end
                blost++;
            end
            if (bit_err !== e_e) begin
                if (berr == 0) begin tb_e = t; ab_e = bit_err; eb_e = e_e; end
                berr++;
            end
            if (t == xn + 1) idle_ok = (in_ready === 1'b1) && (idx == fn) && (tx_o === 1'b1);
            if (in_valid && in_ready) idx++;
        end
        in_valid = 1'b0;
        drv = 1'b1;
        report(tag, "R2/R3 tx sequence", btx, tb_tx, ab_tx, eb_tx);
        report(tag, "R5/R6 arb_lost", blost, tb_l, ab_l, eb_l);
        report(tag, "R7/R8 bit_err", berr, tb_e, ab_e, eb_e);
        report(tag, "R9/R10 idle after frame", idle_ok ? 0 : 1, xn + 1, idle_ok, 1'b1);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int pick;
        void'($urandom(32'h0000_5EED));
        rst = 1'b1; in_valid = 1'b0; in_bit = 1'b1; in_field = 2'b00; in_last = 1'b0;
        drv = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk); #1;
        tests++;
        if (!(tx_o === 1'b1 && in_ready === 1'b1 && arb_lost === 1'b0 && bit_err === 1'b0)) begin
            fails++;
            $display("FAIL R1 reset state: actual tx=%0b rdy=%0b lost=%0b err=%0b expected 1 1 0 0",
                     tx_o, in_ready, arb_lost, bit_err);
        end

        // R3: long dominant runs in arbitration and data
        build(11'h000, 4'd2, 15'h0000, 1'b1);
        run_frame("R3 all-dominant");

        // R4: run of five ones ends right at the last stuffed bit
        build(11'h7FF, 4'd0, 15'h001F, 1'b0);
        run_frame("R4 boundary stuff");

        // R5 R10: lose on a recessive identifier bit
        build(11'h3F1, 4'd3, 15'h1234, 1'b0);
        pick = -1;
        for (int k = 0; k < xn; k++)
            if (pick < 0 && xf[k] == F_ARB && xb[k] && k > 3) pick = k;
        ob[pick] = 1'b0;
        for (int k = pick + 1; k < xn; k++) if ($urandom % 4 == 0) ob[k] = 1'b0;
        run_frame("R5 R10 R8 lost arbitration");

        // R6: other node dominant only where this node is dominant
        build(11'h2F1, 4'd1, 15'h0F0F, 1'b0);
        for (int k = 0; k < xn; k++) if (xf[k] == F_ARB && !xb[k]) ob[k] = 1'b0;
        run_frame("R6 winner");

        // R7: mismatch in data field
        build(11'h155, 4'd4, 15'h2AAA, 1'b0);
        pick = -1;
        for (int k = 0; k < xn; k++)
            if (pick < 0 && xf[k] == F_CTRL && xb[k] && k > 25) pick = k;
        ob[pick] = 1'b0;
        run_frame("R7 data error");

        // R7: mismatch in end of frame
        build(11'h0A5, 4'd0, 15'h0101, 1'b0);
        ob[xn-3] = 1'b0;
        run_frame("R7 fixed-field error");

        // R8: dominant read against recessive arbitration bits never flags bit_err
        build(11'h7F0, 4'd1, 15'h7000, 1'b0);
        ob[2] = 1'b0;
        run_frame("R8 arbitration no error");

        for (int n = 0; n < 24; n++) begin
            build(11'($urandom), 4'($urandom), 15'($urandom), ($urandom % 5) == 0);
            if (n % 2 == 1) begin
                for (int k = 0; k < xn; k++) begin
                    if (xf[k] == F_ARB) begin
                        if ($urandom % 10 == 0) ob[k] = 1'b0;
                    end else if ($urandom % 40 == 0) begin
                        ob[k] = 1'b0;
                    end
                end
            end
            run_frame("R2 R3 random");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule